// File: doc/BRIEF.md
# Processor Machine Status Register

This block holds the control and status flags of a small processor core in one 32-bit register. The bits are numbered with bit 0 as the most significant, so architectural bit n sits at vector index 31-n. Software changes the register in two ways. A full write loads every writable bit on the special-register write port when the address is 0x0001. A bit operation carries an immediate mask and either sets or clears the masked bits. Software reads the register on a special-register read port at the same address. Hardware event inputs set individual status flags: a stream control mismatch, a divide fault, break entry and exception entry.

Carry gets special treatment. A bit operation forwards the new carry to the core in the same cycle through `carry_now`, while every other bit, and carry itself on a full write, becomes visible one cycle later. The most significant bit is a read-only mirror of carry. Build parameters choose which optional flags exist. A flag that is not built reads 0, and neither writes nor events change it.

Top module: `mstat_reg`

## Requirements
- R1: After a synchronous reset every writable bit is 0. `status_out` then shows only the version-present bit (architectural bit 21, index 10), which equals the HAS_PVR parameter.
- R2: A full write (`spr_wr_en` with `spr_wr_addr` = 1) loads the writable bits from `spr_wr_data` and shows them from the next cycle. Reserved bits (architectural 1..16 and 31, indices 30..15 and 0) always read 0. A write to any other address changes nothing.
- R3: A bit-set operation (`bit_op_en`, `bit_op_clr`=0) ORs `bit_op_mask` into the writable bits, visible from the next cycle. During that cycle the read port still returns the value from before the update.
- R4: A bit-clear operation (`bit_op_en`, `bit_op_clr`=1) clears the writable bits that are set in `bit_op_mask`, visible from the next cycle.
- R5: Carry is architectural bit 29 (index 2). During a bit operation, `carry_now` already carries the new carry value. During a full write, `carry_now` keeps the old value until the next cycle. Outside a write, `carry_now` equals the stored carry.
- R6: The carry mirror (architectural bit 0, index 31) always reads the stored carry. Values written to it are ignored.
- R7: Neither kind of write changes the version-present bit.
- R8: The stream error flag (architectural 27, index 4) is sticky. `ev_strm_mismatch` sets it and it stays set until a full write or a bit-clear removes it. If the event and a software clear happen in the same cycle, the event wins.
- R9: `ev_div_fault` sets the divide flag (index 6), `ev_break` sets the break flag (index 3) and `ev_exc_entry` sets the exception-busy flag (index 9). Each takes effect in the next cycle.
- R10: With a feature parameter off, its flags read 0 and ignore writes and events. The parameters and their flags are: HAS_MMU for indices 11..14, HAS_EXC for 8 and 9, HAS_DCACHE for 7, HAS_ICACHE for 5, HAS_DIV for 6 and HAS_STREAM for 4. Interrupt enable (index 1), carry (index 2) and break (index 3) always exist.
- R11: `spr_rd_data` returns the register view when `spr_rd_addr` = 1 and 0 for any other address.
- R12: When a full write and a bit operation arrive in the same cycle, the full write decides the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_wr_en | input | 1 | Special-register write strobe |
| spr_wr_addr | input | ADDR_W | Special-register write address |
| spr_wr_data | input | 32 | Full-write data |
| bit_op_en | input | 1 | Bit operation strobe |
| bit_op_clr | input | 1 | 1 = clear masked bits, 0 = set masked bits |
| bit_op_mask | input | 32 | Immediate mask of the bit operation |
| spr_rd_addr | input | ADDR_W | Special-register read address |
| spr_rd_data | output | 32 | Read data |
| ev_strm_mismatch | input | 1 | Stream control mismatch event |
| ev_div_fault | input | 1 | Divide by zero or overflow event |
| ev_break | input | 1 | Break entry event |
| ev_exc_entry | input | 1 | Hardware exception entry event |
| status_out | output | 32 | Current register view for the core |
| carry_now | output | 1 | Carry with bit-operation forwarding |

## Verification
Full writes are tried with all-ones, all-zeros and alternating patterns, including ones in the mirror, reserved and version bits. These show whether the write mask, the reserved bits and the mirror are honoured. Set and clear masks are applied to known states, so OR can be told apart from AND-NOT and the one-cycle lag can be told apart from immediate effect. The carry is toggled by both write kinds to show which path forwards. Events are raised alone, together with clears and together with writes, to expose the sticky rule and the priorities. Every stimulus also drives a second instance with all features off, and a long random run compares both instances against the model on every cycle.

// File: rtl/mstat_pkg.sv
package mstat_pkg;
  localparam int REG_W = 32;

  // vector index = 31 - architectural bit number
  localparam int POS_INT_EN       = 1;
  localparam int POS_CARRY        = 2;
  localparam int POS_BRK          = 3;
  localparam int POS_STRM_ERR     = 4;
  localparam int POS_ICACHE       = 5;
  localparam int POS_DIV_FLT      = 6;
  localparam int POS_DCACHE       = 7;
  localparam int POS_EXC_EN       = 8;
  localparam int POS_EXC_BUSY     = 9;
  localparam int POS_VER_PRESENT  = 10;
  localparam int POS_USER         = 11;
  localparam int POS_USER_SAVE    = 12;
  localparam int POS_VIRT         = 13;
  localparam int POS_VIRT_SAVE    = 14;
  localparam int POS_CARRY_MIRROR = 31;

  function automatic logic [REG_W-1:0] writable_mask(
    input bit mmu, input bit exc, input bit dc,
    input bit ic, input bit dv, input bit st);
    logic [REG_W-1:0] m;
    m = '0;
    m[POS_INT_EN] = 1'b1;
    m[POS_CARRY]  = 1'b1;
    m[POS_BRK]    = 1'b1;
    m[POS_STRM_ERR] = st;
    m[POS_ICACHE]   = ic;
    m[POS_DIV_FLT]  = dv;
    m[POS_DCACHE]   = dc;
    m[POS_EXC_EN]   = exc;
    m[POS_EXC_BUSY] = exc;
    m[POS_USER]      = mmu;
    m[POS_USER_SAVE] = mmu;
    m[POS_VIRT]      = mmu;
    m[POS_VIRT_SAVE] = mmu;
    return m;
  endfunction
endpackage

// File: rtl/mstat_next.sv
module mstat_next
  import mstat_pkg::*;
#(
  parameter logic [REG_W-1:0] WMASK = '0
) (
  input  logic [REG_W-1:0] cur_q,
  input  logic             full_wr,
  input  logic [REG_W-1:0] full_data,
  input  logic             op_en,
  input  logic             op_clr,
  input  logic [REG_W-1:0] op_mask,
  input  logic [REG_W-1:0] ev_bits,
  output logic [REG_W-1:0] next_q,
  output logic             fwd_carry
);
  logic [REG_W-1:0] sw_val;

  always_comb begin
    if (full_wr)
      sw_val = full_data;
    else if (op_en && op_clr)
      sw_val = cur_q & ~op_mask;
    else if (op_en)
      sw_val = cur_q | op_mask;
    else
      sw_val = cur_q;
    next_q = (sw_val | ev_bits) & WMASK;
    // only a bit operation forwards carry in the same cycle
    fwd_carry = (op_en && !full_wr) ? sw_val[POS_CARRY] : cur_q[POS_CARRY];
  end
endmodule

// File: rtl/mstat_view.sv
module mstat_view
  import mstat_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int SEL_ADDR = 1,
  parameter bit HAS_PVR  = 1'b1
) (
  input  logic [REG_W-1:0]  cur_q,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [REG_W-1:0]  view,
  output logic [REG_W-1:0]  rd_data
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(SEL_ADDR);

  always_comb begin
    view = cur_q;
    view[POS_CARRY_MIRROR] = cur_q[POS_CARRY];
    view[POS_VER_PRESENT]  = HAS_PVR;
    rd_data = (rd_addr == SEL) ? view : '0;
  end
endmodule

// File: rtl/mstat_reg.sv
module mstat_reg
  import mstat_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int SEL_ADDR   = 1,
  parameter bit HAS_PVR    = 1'b1,
  parameter bit HAS_MMU    = 1'b1,
  parameter bit HAS_EXC    = 1'b1,
  parameter bit HAS_DCACHE = 1'b1,
  parameter bit HAS_ICACHE = 1'b1,
  parameter bit HAS_DIV    = 1'b1,
  parameter bit HAS_STREAM = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spr_wr_en,
  input  logic [ADDR_W-1:0] spr_wr_addr,
  input  logic [31:0]       spr_wr_data,
  input  logic              bit_op_en,
  input  logic              bit_op_clr,
  input  logic [31:0]       bit_op_mask,
  input  logic [ADDR_W-1:0] spr_rd_addr,
  output logic [31:0]       spr_rd_data,
  input  logic              ev_strm_mismatch,
  input  logic              ev_div_fault,
  input  logic              ev_break,
  input  logic              ev_exc_entry,
  output logic [31:0]       status_out,
  output logic              carry_now
);
  localparam logic [REG_W-1:0] WMASK =
    writable_mask(HAS_MMU, HAS_EXC, HAS_DCACHE, HAS_ICACHE, HAS_DIV, HAS_STREAM);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(SEL_ADDR);

  logic [REG_W-1:0] msr_q;
  logic [REG_W-1:0] msr_d;
  logic [REG_W-1:0] ev_bits;
  logic             full_wr;

  assign full_wr = spr_wr_en && (spr_wr_addr == SEL);

  always_comb begin
    ev_bits = '0;
    ev_bits[POS_STRM_ERR] = ev_strm_mismatch;
    ev_bits[POS_DIV_FLT]  = ev_div_fault;
    ev_bits[POS_BRK]      = ev_break;
    ev_bits[POS_EXC_BUSY] = ev_exc_entry;
  end

  mstat_next #(.WMASK(WMASK)) u_next (
    .cur_q     (msr_q),
    .full_wr   (full_wr),
    .full_data (spr_wr_data),
    .op_en     (bit_op_en),
    .op_clr    (bit_op_clr),
    .op_mask   (bit_op_mask),
    .ev_bits   (ev_bits),
    .next_q    (msr_d),
    .fwd_carry (carry_now)
  );

  always_ff @(posedge clk) begin
    if (rst) msr_q <= '0;
    else     msr_q <= msr_d;
  end

  mstat_view #(.ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .HAS_PVR(HAS_PVR)) u_view (
    .cur_q   (msr_q),
    .rd_addr (spr_rd_addr),
    .view    (status_out),
    .rd_data (spr_rd_data)
  );
endmodule

// File: rtl/mstat_reg_chk.sv
module mstat_reg_chk
  import mstat_pkg::*;
#(
  parameter int ADDR_W     = 14,
  parameter int SEL_ADDR   = 1,
  parameter bit HAS_PVR    = 1'b1,
  parameter bit HAS_MMU    = 1'b1,
  parameter bit HAS_EXC    = 1'b1,
  parameter bit HAS_DCACHE = 1'b1,
  parameter bit HAS_ICACHE = 1'b1,
  parameter bit HAS_DIV    = 1'b1,
  parameter bit HAS_STREAM = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              spr_wr_en,
  input logic [ADDR_W-1:0] spr_wr_addr,
  input logic [31:0]       spr_wr_data,
  input logic              bit_op_en,
  input logic              bit_op_clr,
  input logic [31:0]       bit_op_mask,
  input logic              ev_strm_mismatch,
  input logic              ev_div_fault,
  input logic              ev_break,
  input logic              ev_exc_entry,
  input logic [31:0]       status_out,
  input logic              carry_now
);
  localparam logic [REG_W-1:0] WM =
    writable_mask(HAS_MMU, HAS_EXC, HAS_DCACHE, HAS_ICACHE, HAS_DIV, HAS_STREAM);
  logic fw, anyev;
  assign fw    = spr_wr_en && (spr_wr_addr == ADDR_W'(SEL_ADDR));
  assign anyev = ev_strm_mismatch | ev_div_fault | ev_break | ev_exc_entry;

  assert_full_write_R2: assert property (@(posedge clk) disable iff (rst)
    (fw && !anyev) |=> ((status_out & WM) == ($past(spr_wr_data) & WM)));

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (status_out[30:15] == '0) && !status_out[0]);

  assert_carry_forward_R5: assert property (@(posedge clk) disable iff (rst)
    (bit_op_en && !fw) |=> (status_out[POS_CARRY] == $past(carry_now)));

  assert_carry_idle_R5: assert property (@(posedge clk) disable iff (rst)
    (!bit_op_en && !fw) |-> (carry_now == status_out[POS_CARRY]));

  assert_version_fixed_R7: assert property (@(posedge clk) disable iff (rst)
    $stable(status_out[POS_VER_PRESENT]));

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (status_out[POS_STRM_ERR] && !fw && !(bit_op_en && bit_op_clr))
      |=> status_out[POS_STRM_ERR]);

  assert_event_wins_R8: assert property (@(posedge clk) disable iff (rst)
    (ev_strm_mismatch && HAS_STREAM) |=> status_out[POS_STRM_ERR]);

  assert_break_event_R9: assert property (@(posedge clk) disable iff (rst)
    ev_break |=> status_out[POS_BRK]);
endmodule

bind mstat_reg mstat_reg_chk #(
  .ADDR_W(ADDR_W), .SEL_ADDR(SEL_ADDR), .HAS_PVR(HAS_PVR), .HAS_MMU(HAS_MMU),
  .HAS_EXC(HAS_EXC), .HAS_DCACHE(HAS_DCACHE), .HAS_ICACHE(HAS_ICACHE),
  .HAS_DIV(HAS_DIV), .HAS_STREAM(HAS_STREAM)
) u_chk (
  .clk(clk), .rst(rst), .spr_wr_en(spr_wr_en), .spr_wr_addr(spr_wr_addr),
  .spr_wr_data(spr_wr_data), .bit_op_en(bit_op_en), .bit_op_clr(bit_op_clr),
  .bit_op_mask(bit_op_mask), .ev_strm_mismatch(ev_strm_mismatch),
  .ev_div_fault(ev_div_fault), .ev_break(ev_break), .ev_exc_entry(ev_exc_entry),
  .status_out(status_out), .carry_now(carry_now)
);

// File: tb/mstat_reg_test.sv
module mstat_reg_test;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic op_en = 1'b0;
  logic op_clr = 1'b0;
  logic [31:0] op_mask = '0;
  logic [AW-1:0] rd_addr = AW'(1);
  logic e_strm = 1'b0, e_div = 1'b0, e_brk = 1'b0, e_exc = 1'b0;
  logic [31:0] rd1, st1, rd2, st2;
  logic cy1, cy2;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit started = 1'b0;
  string cur_req = "R1";

  always #2 clk = ~clk;

  mstat_reg #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .spr_wr_en(wr_en), .spr_wr_addr(wr_addr),
    .spr_wr_data(wr_data), .bit_op_en(op_en), .bit_op_clr(op_clr),
    .bit_op_mask(op_mask), .spr_rd_addr(rd_addr), .spr_rd_data(rd1),
    .ev_strm_mismatch(e_strm), .ev_div_fault(e_div), .ev_break(e_brk),
    .ev_exc_entry(e_exc), .status_out(st1), .carry_now(cy1));

  // R10: instance with every optional feature and the version bit off
  mstat_reg #(.ADDR_W(AW), .HAS_PVR(1'b0), .HAS_MMU(1'b0), .HAS_EXC(1'b0),
    .HAS_DCACHE(1'b0), .HAS_ICACHE(1'b0), .HAS_DIV(1'b0), .HAS_STREAM(1'b0)) uut2 (
    .clk(clk), .rst(rst), .spr_wr_en(wr_en), .spr_wr_addr(wr_addr),
    .spr_wr_data(wr_data), .bit_op_en(op_en), .bit_op_clr(op_clr),
    .bit_op_mask(op_mask), .spr_rd_addr(rd_addr), .spr_rd_data(rd2),
    .ev_strm_mismatch(e_strm), .ev_div_fault(e_div), .ev_break(e_brk),
    .ev_exc_entry(e_exc), .status_out(st2), .carry_now(cy2));

  function automatic logic [31:0] abit(int n);
    return 32'd1 << (31 - n);
  endfunction

  function automatic logic [31:0] allowed(bit full_feat);
    logic [31:0] m;
    m = abit(30) | abit(29) | abit(28);
    if (full_feat)
      for (int n = 17; n <= 27; n++) if (n != 21) m |= abit(n);
    return m;
  endfunction

  function automatic logic [31:0] sw_val(logic [31:0] q);
    if (wr_en && wr_addr == AW'(1)) return wr_data;
    if (op_en) return op_clr ? (q & ~op_mask) : (q | op_mask);
    return q;
  endfunction

  function automatic logic [31:0] model_next(logic [31:0] q, bit full_feat);
    logic [31:0] ev;
    ev = (e_strm ? abit(27) : 0) | (e_div ? abit(25) : 0) |
         (e_brk ? abit(28) : 0) | (e_exc ? abit(22) : 0);
    return (sw_val(q) | ev) & allowed(full_feat);
  endfunction

  function automatic logic [31:0] view(logic [31:0] q, bit pvr);
    logic [31:0] v;
    v = q;
    if (q & abit(29)) v |= abit(0);
    if (pvr) v |= abit(21);
    return v;
  endfunction

  logic [31:0] m1 = '0, m2 = '0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    started <= 1'b1;
    if (rst) begin m1 <= '0; m2 <= '0; end
    else begin
      m1 <= model_next(m1, 1'b1);
      m2 <= model_next(m2, 1'b0);
    end
  end

  task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  function automatic logic exp_carry(logic [31:0] q);
    logic [31:0] s;
    s = sw_val(q);
    if (op_en && !(wr_en && wr_addr == AW'(1))) return s[2];
    return q[2];
  endfunction

  always @(negedge clk) begin
    if (started) begin
      chk("status", st1, view(m1, 1'b1));
      chk("rdata", rd1, rd_addr == AW'(1) ? view(m1, 1'b1) : 32'h0);
      chk("carry", {31'd0, cy1}, {31'd0, rst ? 1'b0 : exp_carry(m1)});
      chk("status_nofeat", st2, view(m2, 1'b0));
      chk("rdata_nofeat", rd2, rd_addr == AW'(1) ? view(m2, 1'b0) : 32'h0);
      chk("carry_nofeat", {31'd0, cy2}, {31'd0, rst ? 1'b0 : exp_carry(m2)});
    end
  end

  task automatic idle();
    wr_en = 0; op_en = 0; op_clr = 0; e_strm = 0; e_div = 0; e_brk = 0; e_exc = 0;
    rd_addr = AW'(1);
  endtask

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic full_wr(logic [31:0] d, logic [AW-1:0] a = AW'(1));
    idle(); wr_en = 1; wr_addr = a; wr_data = d; step(); idle(); step();
  endtask

  task automatic bit_op(bit clr, logic [31:0] m);
    idle(); op_en = 1; op_clr = clr; op_mask = m; step(); idle(); step();
  endtask

  initial begin
    step(3);
    cur_req = "R1"; rst = 0; idle(); step(2);
    cur_req = "R2"; full_wr(32'hFFFF_FFFF); full_wr(32'h0); full_wr(32'hAAAA_AAAA);
    full_wr(32'h5555_5555); full_wr(32'hFFFF_FFFF, AW'(2));
    cur_req = "R11"; rd_addr = AW'(0); step(); rd_addr = AW'(3); step(); idle();
    cur_req = "R3"; full_wr(32'h0); bit_op(0, abit(30) | abit(23)); bit_op(0, abit(18));
    cur_req = "R4"; bit_op(1, abit(23)); bit_op(1, 32'hFFFF_FFFF);
    cur_req = "R5"; bit_op(0, abit(29)); bit_op(1, abit(29)); full_wr(abit(29));
    full_wr(32'h0);
    cur_req = "R6"; full_wr(abit(0)); bit_op(0, abit(0)); bit_op(0, abit(29));
    bit_op(1, abit(0));
    cur_req = "R7"; full_wr(abit(21)); bit_op(1, abit(21)); bit_op(0, abit(21));
    cur_req = "R8"; full_wr(32'h0);
    idle(); e_strm = 1; step(); idle(); step(3);
    bit_op(0, abit(30)); bit_op(1, abit(30)); full_wr(abit(27) ^ abit(27) | abit(30));
    idle(); e_strm = 1; step(); idle(); step();
    bit_op(1, abit(27));
    idle(); e_strm = 1; step(); idle(); step();
    idle(); e_strm = 1; op_en = 1; op_clr = 1; op_mask = abit(27); step(); idle(); step();
    idle(); e_strm = 1; wr_en = 1; wr_addr = AW'(1); wr_data = 0; step(); idle(); step();
    cur_req = "R9"; full_wr(32'h0);
    idle(); e_div = 1; step(); idle(); e_brk = 1; step(); idle(); e_exc = 1; step();
    idle(); step();
    cur_req = "R10"; full_wr(32'hFFFF_FFFF); bit_op(1, 32'h0); bit_op(0, 32'hFFFF_FFFF);
    cur_req = "R12"; full_wr(32'h0);
    idle(); wr_en = 1; wr_addr = AW'(1); wr_data = abit(30); op_en = 1; op_clr = 0;
    op_mask = abit(29); step(); idle(); step();
    cur_req = "R1"; rst = 1; step(2); rst = 0; step();
    cur_req = "R2";
    for (int i = 0; i < 600; i++) begin
      wr_en = ($urandom % 4) == 0; wr_addr = AW'($urandom % 3); wr_data = $urandom;
      op_en = ($urandom % 3) == 0; op_clr = $urandom; op_mask = $urandom;
      e_strm = ($urandom % 6) == 0; e_div = ($urandom % 8) == 0;
      e_brk = ($urandom % 8) == 0; e_exc = ($urandom % 8) == 0;
      rd_addr = AW'($urandom % 2);
      step();
    end
    idle(); step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cycles > 50000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule